// File: doc/BRIEF.md
# Clock-Supervision Interrupt Aggregator

This block collects nine event lines from the clock-supervision logic of a timing device and records each one in a sticky status bit. Each status bit has its own mask bit. The block raises a single interrupt request whenever a recorded event is also unmasked. Software uses a small register port to read the status, mask and control registers. To acknowledge an event, software writes a one to that event's status bit.

The request pin is modelled as a data value plus an output enable. Its active level can be programmed. It can also run in push-pull mode, or in a mode where it is driven only while the request is active and floats otherwise. One event, the failure of the primary path's selected input, can also be copied to a second pin when a routing bit is set. The monitors and loops that produce the events sit outside this block.

Event bit order, LSB first:
- bit 0: oscillator fail
- bit 1: line-code violation
- bit 2: loss of signal
- bit 3: secondary-loop lock change
- bit 4: primary-input validity change
- bit 5: primary selected-input fail
- bit 6: secondary path left without a qualified input
- bit 7: primary loop mode switch
- bit 8: external sync alarm

Top module: `clkmon_irq_agg`

## Requirements
- R1: A rising edge on an event input `evt_i[n]` sets status bit n at the next clock edge. The status bit then reads back as bit n at address 0.
- R2: Writing address 0 clears exactly those status bits whose data bit is 1. A status bit written with 0 keeps its value.
- R3: When a rising event and a write-one clear reach the same status bit in the same cycle, the bit ends up set.
- R4: Status bits are recorded whatever the mask holds. A mask bit (address 1, bit n, 1 = enabled) affects only the request.
- R5: The request is active while at least one status bit is set together with its mask bit. It stays active until every such bit has been cleared.
- R6: Control bit 0 (address 2) selects the active level of `irq_o`: 1 = active high, 0 = active low.
- R7: When control bit 1 is 0, `irq_oe_o` is always 1. When control bit 1 is 1, `irq_oe_o` is 1 only while the request is active.
- R8: When control bit 2 is 1, `alt_oe_o` is 1 and `alt_o` follows status bit 5. When control bit 2 is 0, both outputs are 0.
- R9: While reset is asserted, the status, mask and control registers are all zero. As a result, `irq_o` is 1, `irq_oe_o` is 1, and `alt_o` and `alt_oe_o` are 0.
- R10: An event input held high sets its status bit only once. After software clears the bit, it stays clear until the input falls and rises again.
- R11: Reads return the register contents zero-extended. Mask bits above the event count and control bits above bit 2 read as 0. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVT | Synchronous event lines from the supervisors |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address (0 status, 1 mask, 2 control) |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| irq_o | output | 1 | Request pin data value |
| irq_oe_o | output | 1 | Request pin output enable |
| alt_o | output | 1 | Second pin data value (selected-input fail) |
| alt_oe_o | output | 1 | Second pin output enable |

## Verification
The bench uses the default build: nine events, a 4-bit address, 16-bit data, event 5 as the routed fail, and a two-stage reset synchronizer. With 16-bit data, the write data can carry bits above the event count, so the masking of unused mask and control bits can be observed at the port. With nine events, the all-events-at-once pattern and the top bit, event 8, can be exercised. Routing event 5 lets the second pin be checked against events on neighbouring bits that must not affect it.

// File: rtl/clkmon_irq_pkg.sv
package clkmon_irq_pkg;

  localparam int unsigned ADR_STAT = 0;
  localparam int unsigned ADR_MASK = 1;
  localparam int unsigned ADR_CTRL = 2;
  localparam int unsigned CTRL_W   = 3;

  typedef struct packed {
    logic route;
    logic hiz;
    logic act_high;
  } ctrl_t;

endpackage

// File: rtl/clkmon_irq_edge.sv
module clkmon_irq_edge #(
  parameter int unsigned N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] rise_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= evt_i[g];
    end

    assign rise_o[g] = evt_i[g] & ~prev_q;

    assert_rise_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end

endmodule

// File: rtl/clkmon_irq_regs.sv
module clkmon_irq_regs
  import clkmon_irq_pkg::*;
#(
  parameter int unsigned N  = 9,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  rise_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [N-1:0]  status_o,
  output ctrl_t         ctrl_o,
  output logic          pend_o
);

  logic [N-1:0] status_q, status_d;
  logic [N-1:0] mask_q, mask_d;
  ctrl_t        ctrl_q, ctrl_d;
  logic [N-1:0] clr_vec;
  logic         sel_stat, sel_mask, sel_ctrl;
  logic         mask_we, ctrl_we;
  logic         unused_wdata;

  assign sel_stat = (addr_i == AW'(ADR_STAT));
  assign sel_mask = (addr_i == AW'(ADR_MASK));
  assign sel_ctrl = (addr_i == AW'(ADR_CTRL));
  assign mask_we  = wr_i & sel_mask;
  assign ctrl_we  = wr_i & sel_ctrl;
  assign unused_wdata = ^wdata_i[DW-1:N];

  always_comb begin
    clr_vec  = (wr_i && sel_stat) ? wdata_i[N-1:0] : '0;
    status_d = (status_q & ~clr_vec) | rise_i;
    mask_d   = wdata_i[N-1:0];
    ctrl_d   = ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      ctrl_q   <= '0;
    end else begin
      status_q <= status_d;
      if (mask_we) mask_q <= mask_d;
      if (ctrl_we) ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_stat)      rdata_o = DW'(status_q);
    else if (sel_mask) rdata_o = DW'(mask_q);
    else if (sel_ctrl) rdata_o = DW'(ctrl_q);
  end

  assign status_o = status_q;
  assign ctrl_o   = ctrl_q;
  assign pend_o   = |(status_q & mask_q);

  assert_clear_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_q) & ~status_q) != '0) |-> $past(wr_i && sel_stat));

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i != '0) |=> ((status_q & $past(rise_i)) == $past(rise_i)));

  assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));

endmodule

// File: rtl/clkmon_irq_drive.sv
module clkmon_irq_drive
  import clkmon_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pend_i,
  input  logic  fail_i,
  input  ctrl_t ctrl_i,
  output logic  irq_o,
  output logic  irq_oe_o,
  output logic  alt_o,
  output logic  alt_oe_o
);

  always_comb begin
    irq_o    = ctrl_i.act_high ? pend_i : ~pend_i;
    irq_oe_o = ctrl_i.hiz ? pend_i : 1'b1;
    alt_oe_o = ctrl_i.route;
    alt_o    = ctrl_i.route & fail_i;
  end

  assert_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_i |-> (irq_o == ctrl_i.act_high));

  assert_pushpull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i.hiz |-> irq_oe_o);

  assert_float_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.hiz && !pend_i) |-> !irq_oe_o);

  assert_alt_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i.route |-> (!alt_oe_o && !alt_o));

endmodule

// File: rtl/clkmon_irq_agg.sv
module clkmon_irq_agg
  import clkmon_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 9,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FAIL_IDX = 5,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              irq_oe_o,
  output logic              alt_o,
  output logic              alt_oe_o
);

  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_n;
  logic [NUM_EVT-1:0]  rise;
  logic [NUM_EVT-1:0]  status;
  ctrl_t               ctrl;
  logic                pend;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= '0;
    else          rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[SYNC_STG-1];

  clkmon_irq_edge #(.N(NUM_EVT)) u_edge (
    .clk    (clk_i),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .rise_o (rise)
  );

  clkmon_irq_regs #(.N(NUM_EVT), .AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk      (clk_i),
    .rst_n    (rst_n),
    .rise_i   (rise),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .status_o (status),
    .ctrl_o   (ctrl),
    .pend_o   (pend)
  );

  clkmon_irq_drive u_drive (
    .clk      (clk_i),
    .rst_n    (rst_n),
    .pend_i   (pend),
    .fail_i   (status[FAIL_IDX]),
    .ctrl_i   (ctrl),
    .irq_o    (irq_o),
    .irq_oe_o (irq_oe_o),
    .alt_o    (alt_o),
    .alt_oe_o (alt_oe_o)
  );

  assert_event_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rise != '0) |=> ((status & $past(rise)) != '0));

  assert_reset_quiet_R9: assert property (@(posedge clk_i)
    !rst_n |-> (status == '0 && !pend));

endmodule

// File: tb/clkmon_irq_agg_tb_top.sv
`timescale 1ns/1ps
module clkmon_irq_agg_tb_top;

  localparam int N  = 9;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  evt;
  logic          wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq, irq_oe, alt, alt_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  clkmon_irq_agg dut_i (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .evt_i       (evt),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .irq_oe_o    (irq_oe),
    .alt_o       (alt),
    .alt_oe_o    (alt_oe)
  );

  typedef struct packed {
    logic [8:0] evt;
    logic [8:0] en;
    logic [2:0] ctrl;
    logic       irq;
    logic       oe;
    logic       alt;
    logic       alt_oe;
    logic [8:0] stat;
  } vec_t;

  // Fields: evt, mask, control, irq, irq_oe, alt, alt_oe, status
  localparam vec_t VECS [10] = '{
    '{9'h001, 9'h001, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 9'h001},
    '{9'h001, 9'h000, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 9'h001},
    '{9'h008, 9'h008, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 9'h008},
    '{9'h008, 9'h004, 3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 9'h008},
    '{9'h100, 9'h1FF, 3'b010, 1'b0, 1'b1, 1'b0, 1'b0, 9'h100},
    '{9'h000, 9'h1FF, 3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000},
    '{9'h020, 9'h000, 3'b100, 1'b1, 1'b1, 1'b1, 1'b1, 9'h020},
    '{9'h020, 9'h020, 3'b111, 1'b1, 1'b1, 1'b1, 1'b1, 9'h020},
    '{9'h010, 9'h000, 3'b100, 1'b1, 1'b1, 1'b0, 1'b1, 9'h010},
    '{9'h1FF, 9'h1FF, 3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 9'h1FF}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] rd;
    rst_n = 1'b0; evt = '0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 irq", DW'(irq), 16'h1);
    check("R9 irq_oe", DW'(irq_oe), 16'h1);
    check("R9 alt_oe", DW'(alt_oe), 16'h0);
    reg_read(4'd0, rd); check("R9 status", rd, 16'h0);
    reg_read(4'd2, rd); check("R9 control", rd, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Vector walk: R1, R4, R5, R6, R7, R8
    for (int i = 0; i < 10; i++) begin
      reg_write(4'd0, 16'hFFFF);
      reg_write(4'd1, DW'(VECS[i].en));
      reg_write(4'd2, DW'(VECS[i].ctrl));
      pulse(VECS[i].evt);
      check($sformatf("R6 vec%0d irq", i), DW'(irq), DW'(VECS[i].irq));
      check($sformatf("R7 vec%0d irq_oe", i), DW'(irq_oe), DW'(VECS[i].oe));
      check($sformatf("R8 vec%0d alt", i), DW'(alt), DW'(VECS[i].alt));
      check($sformatf("R8 vec%0d alt_oe", i), DW'(alt_oe), DW'(VECS[i].alt_oe));
      reg_read(4'd0, rd);
      check($sformatf("R1 R4 vec%0d status", i), rd, DW'(VECS[i].stat));
    end

    // R2 and R5: write-0 ignored, request held until all enabled cleared
    reg_write(4'd0, 16'hFFFF);
    reg_write(4'd1, 16'h0003);
    reg_write(4'd2, 16'h0000);
    pulse(9'h003);
    reg_write(4'd0, 16'h0000);
    reg_read(4'd0, rd); check("R2 write zero", rd, 16'h0003);
    reg_write(4'd0, 16'h0001);
    reg_read(4'd0, rd); check("R2 partial clear", rd, 16'h0002);
    check("R5 still pending", DW'(irq), 16'h0);
    reg_write(4'd0, 16'h0002);
    check("R5 released", DW'(irq), 16'h1);

    // R3: set and clear collide on bit 2
    reg_write(4'd0, 16'hFFFF);
    @(negedge clk);
    evt = 9'h004; wr = 1'b1; addr = 4'd0; wdata = 16'h0004;
    @(negedge clk);
    wr = 1'b0; evt = '0; wdata = '0;
    reg_read(4'd0, rd); check("R3 set wins", rd, 16'h0004);

    // R10: held-high input sets once
    reg_write(4'd0, 16'hFFFF);
    @(negedge clk); evt = 9'h040;
    repeat (2) @(negedge clk);
    reg_read(4'd0, rd); check("R10 first set", rd, 16'h0040);
    reg_write(4'd0, 16'h0040);
    repeat (3) @(negedge clk);
    reg_read(4'd0, rd); check("R10 no re-set while high", rd, 16'h0000);
    @(negedge clk); evt = '0;
    @(negedge clk);

    // R11: readback masking and unmapped address
    reg_write(4'd1, 16'hFFFF);
    reg_read(4'd1, rd); check("R11 mask width", rd, 16'h01FF);
    reg_write(4'd2, 16'hFFFF);
    reg_read(4'd2, rd); check("R11 control width", rd, 16'h0007);
    reg_read(4'd3, rd); check("R11 unmapped", rd, 16'h0000);

    // R9: reset mid-run
    pulse(9'h021);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R9 mid irq", DW'(irq), 16'h1);
    check("R9 mid irq_oe", DW'(irq_oe), 16'h1);
    check("R9 mid alt_oe", DW'(alt_oe), 16'h0);
    reg_read(4'd0, rd); check("R9 mid status", rd, 16'h0);
    reg_read(4'd1, rd); check("R9 mid mask", rd, 16'h0);

    finish_run();
  end

endmodule